// File: doc/BRIEF.md
# Coded-Ratio Reference Frequency Divider

This block takes a reference clock and produces the phase-comparison rate for a frequency synthesiser loop. A four-bit ratio code chooses one of sixteen fixed division ratios. The code has a mode bit and a three-bit select. Mode 0 gives a power-of-two series from 2 to 256. Mode 1 gives a series that starts 3, 5 and then doubles up to 320.

Each divided period produces one comparison strobe that is one reference cycle wide. A near-square copy of the divided clock is also produced, so that the comparison rate can be observed on a test pin. A new code is written by presenting it with a valid strobe. It is held as pending and takes over only at the next terminal count, so a period that is already running always completes with its old length.

Internally the block is a down-counter that reloads with the ratio minus one whenever it reaches zero. The asynchronous reset is released through a two-stage synchroniser. After reset the block divides by 2.

Top module: `cmp_ref_divider`

## Requirements
- R1: While reset is asserted, and until the core leaves reset, `cmp_strobe` and `div_sq` are 0. After reset the ratio is 2 (code 0000). The first strobe appears on the third rising edge after `rst_n` is released, and the next one follows 2 cycles later.
- R2: With `ratio_code[3]` = 0, the select `ratio_code[2:0]` values 0 to 7 give periods of 2, 4, 8, 16, 32, 64, 128 and 256 reference cycles.
- R3: With `ratio_code[3]` = 1, the select values 0 to 7 give periods of 3, 5, 10, 20, 40, 80, 160 and 320 reference cycles.
- R4: `cmp_strobe` is high for exactly one cycle per divided period. The spacing between two strobes equals the ratio that was active for that period.
- R5: `ratio_code` is captured only on a rising edge where `code_vld` is 1. A code presented with `code_vld` = 0 has no effect on the period.
- R6: A captured code becomes active only at the terminal count, on the same edge that raises the strobe. The period that is running when the code arrives keeps its old length.
- R7: `div_sq` rises together with each strobe. It stays high for ceil(N/2) cycles and low for floor(N/2) cycles, so for odd N the high phase is one cycle longer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ratio_code | input | 4 | Bit 3 is the series mode; bits 2:0 are the select |
| code_vld | input | 1 | Captures `ratio_code` as the pending code |
| cmp_strobe | output | 1 | One-cycle pulse per divided period |
| div_sq | output | 1 | Near-square divided clock for observation |

## Verification
The bench sweeps all sixteen codes and measures the spacing between strobes. A wrong table entry, or a wrong odd-ratio case, would show up as a bad period for that code, such as a ratio of 4 where 3 was asked. It writes a code in the middle of a long 256-cycle period. A design that applies codes at once would cut that period short. It also presents codes with the valid strobe low, and a design that ignored `code_vld` would change ratio. Across random code writes, it compares the high and low lengths of `div_sq` cycle by cycle for odd ratios, where an off-by-one in the half-period compare swaps the longer phase.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

  typedef enum logic {
    SERIES_POW2  = 1'b0,
    SERIES_MIXED = 1'b1
  } ratio_series_e;

  // Ratio for a series and a select value.
  function automatic int unsigned ratio_calc(input ratio_series_e series,
                                             input int unsigned sel);
    int unsigned r;
    if (series == SERIES_POW2) begin
      r = 32'd2 << sel;
    end else if (sel == 0) begin
      r = 32'd3;
    end else begin
      r = 32'd5 << (sel - 1);
    end
    return r;
  endfunction

  // Largest ratio for a given select width.
  function automatic int unsigned ratio_max(input int unsigned sel_w);
    return ratio_calc(SERIES_MIXED, (32'd1 << sel_w) - 1);
  endfunction

endpackage

// File: rtl/refdiv_rst_sync.sv
module refdiv_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;

endmodule

// File: rtl/refdiv_ratio_lut.sv
module refdiv_ratio_lut #(
  parameter int SEL_W = 3,
  parameter int CNT_W = 9
) (
  input  logic [SEL_W:0]   code,
  output logic [CNT_W-1:0] ratio,
  output logic [CNT_W-1:0] half
);

  localparam int NSEL   = 1 << SEL_W;
  localparam int NCODES = 2 * NSEL;

  logic [CNT_W-1:0] tbl [NCODES];

  for (genvar g = 0; g < NCODES; g++) begin : g_tbl
    localparam refdiv_pkg::ratio_series_e SER =
      refdiv_pkg::ratio_series_e'(g / NSEL);
    localparam int unsigned VAL = refdiv_pkg::ratio_calc(SER, g % NSEL);
    assign tbl[g] = CNT_W'(VAL);
  end

  always_comb begin
    ratio = tbl[code];
    half  = ratio >> 1;
  end

endmodule

// File: rtl/refdiv_code_reg.sv
module refdiv_code_reg #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code_in,
  input  logic              code_vld,
  input  logic              tc,
  output logic [CODE_W-1:0] pend_code,
  output logic [CODE_W-1:0] act_code
);

  logic [CODE_W-1:0] pend_q, pend_d;
  logic [CODE_W-1:0] act_q, act_d;
  logic              pend_en;
  logic              act_en;

  assign pend_en = code_vld;
  assign act_en  = tc;

  always_comb begin
    pend_d = pend_q;
    act_d  = act_q;
    if (pend_en) pend_d = code_in;
    if (act_en)  act_d  = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  assign pend_code = pend_q;
  assign act_code  = act_q;

endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] reload_ratio,
  output logic             tc,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             strobe
);

  logic [CNT_W-1:0] cnt_q;
  logic             strobe_q;

  assign tc = (cnt_q == '0);

  always_comb begin
    if (tc) begin
      cnt_nxt = reload_ratio - CNT_W'(1);
    end else begin
      cnt_nxt = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      strobe_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_nxt;
      strobe_q <= tc;
    end
  end

  assign strobe = strobe_q;

endmodule

// File: rtl/refdiv_phase.sv
module refdiv_phase #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tc,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] act_half,
  output logic             sq
);

  logic sq_q, sq_d;

  // High while the count is at or above the half point. A reload always starts high.
  always_comb begin
    if (tc) begin
      sq_d = 1'b1;
    end else begin
      sq_d = (cnt_nxt >= act_half);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_q <= 1'b0;
    end else begin
      sq_q <= sq_d;
    end
  end

  assign sq = sq_q;

endmodule

// File: rtl/cmp_ref_divider.sv
module cmp_ref_divider #(
  parameter int SEL_W = 3
) (
  input  logic           clk_ref,
  input  logic           rst_n,
  input  logic [SEL_W:0] ratio_code,
  input  logic           code_vld,
  output logic           cmp_strobe,
  output logic           div_sq
);

  localparam int CODE_W    = SEL_W + 1;
  localparam int MAX_RATIO = int'(refdiv_pkg::ratio_max(SEL_W));
  localparam int CNT_W     = $clog2(MAX_RATIO + 1);

  logic              core_rst_n;
  logic [CODE_W-1:0] pend_code;
  logic [CODE_W-1:0] act_code;
  logic [CNT_W-1:0]  next_ratio;
  logic [CNT_W-1:0]  next_half;
  logic [CNT_W-1:0]  act_ratio;
  logic [CNT_W-1:0]  act_half;
  logic              tc;
  logic [CNT_W-1:0]  cnt_nxt;

  refdiv_rst_sync u_rst (
    .clk        (clk_ref),
    .rst_n      (rst_n),
    .rst_sync_n (core_rst_n)
  );

  refdiv_code_reg #(.CODE_W(CODE_W)) u_code (
    .clk       (clk_ref),
    .rst_n     (core_rst_n),
    .code_in   (ratio_code),
    .code_vld  (code_vld),
    .tc        (tc),
    .pend_code (pend_code),
    .act_code  (act_code)
  );

  refdiv_ratio_lut #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_lut_next (
    .code  (pend_code),
    .ratio (next_ratio),
    .half  (next_half)
  );

  refdiv_ratio_lut #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_lut_act (
    .code  (act_code),
    .ratio (act_ratio),
    .half  (act_half)
  );

  refdiv_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk          (clk_ref),
    .rst_n        (core_rst_n),
    .reload_ratio (next_ratio),
    .tc           (tc),
    .cnt_nxt      (cnt_nxt),
    .strobe       (cmp_strobe)
  );

  refdiv_phase #(.CNT_W(CNT_W)) u_phase (
    .clk      (clk_ref),
    .rst_n    (core_rst_n),
    .tc       (tc),
    .cnt_nxt  (cnt_nxt),
    .act_half (act_half),
    .sq       (div_sq)
  );

  logic unused_ok;
  assign unused_ok = ^{next_half, act_ratio};

endmodule

// File: rtl/refdiv_chk.sv
module refdiv_chk #(
  parameter int SEL_W = 3
) (
  input logic           clk_ref,
  input logic           rst_n,
  input logic           core_rst_n,
  input logic [SEL_W:0] ratio_code,
  input logic           code_vld,
  input logic [SEL_W:0] pend_code,
  input logic [SEL_W:0] act_code,
  input logic           cmp_strobe,
  input logic           div_sq
);

  localparam int MAX_RATIO = int'(refdiv_pkg::ratio_max(SEL_W));
  localparam int GAP_W     = $clog2(MAX_RATIO + 2) + 1;

  logic [GAP_W-1:0] gap_q;
  logic             seen_q;

  always_ff @(posedge clk_ref or negedge core_rst_n) begin
    if (!core_rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (cmp_strobe) begin
      gap_q  <= GAP_W'(1);
      seen_q <= 1'b1;
    end else if (gap_q != '1) begin
      gap_q  <= gap_q + GAP_W'(1);
    end
  end

  always @(posedge clk_ref) begin
    if (!core_rst_n) begin
      AST_RST_QUIET: assert (!cmp_strobe && !div_sq); // R1
    end
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk_ref) disable iff (!core_rst_n)
    cmp_strobe |=> !cmp_strobe); // R4

  AST_GAP_LEGAL: assert property (@(posedge clk_ref) disable iff (!core_rst_n)
    (cmp_strobe && seen_q) |-> (gap_q >= GAP_W'(2) && gap_q <= GAP_W'(MAX_RATIO))); // R4

  AST_PEND_CAPTURE: assert property (@(posedge clk_ref) disable iff (!core_rst_n)
    code_vld |=> (pend_code == $past(ratio_code))); // R5

  AST_PEND_HOLD: assert property (@(posedge clk_ref) disable iff (!core_rst_n)
    !code_vld |=> $stable(pend_code)); // R5

  AST_ACT_AT_TC: assert property (@(posedge clk_ref) disable iff (!core_rst_n)
    !$stable(act_code) |-> cmp_strobe); // R6

  AST_SQ_RISE_WITH_STB: assert property (@(posedge clk_ref) disable iff (!core_rst_n)
    cmp_strobe |-> div_sq); // R7

  AST_SQ_LOW_BEFORE_STB: assert property (@(posedge clk_ref) disable iff (!core_rst_n)
    (cmp_strobe && seen_q) |-> !$past(div_sq)); // R7

  logic unused_ok;
  assign unused_ok = rst_n;

endmodule

bind cmp_ref_divider refdiv_chk #(.SEL_W(SEL_W)) u_chk (
  .clk_ref    (clk_ref),
  .rst_n      (rst_n),
  .core_rst_n (core_rst_n),
  .ratio_code (ratio_code),
  .code_vld   (code_vld),
  .pend_code  (pend_code),
  .act_code   (act_code),
  .cmp_strobe (cmp_strobe),
  .div_sq     (div_sq)
);

// File: tb/cmp_ref_divider_bench.sv
`timescale 1ns/1ps
module cmp_ref_divider_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] ratio_code;
  logic       code_vld;
  logic       cmp_strobe;
  logic       div_sq;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  cmp_ref_divider u_cmp_ref_divider (
    .clk_ref    (clk),
    .rst_n      (rst_n),
    .ratio_code (ratio_code),
    .code_vld   (code_vld),
    .cmp_strobe (cmp_strobe),
    .div_sq     (div_sq)
  );

  function automatic int ratio_ref(input logic [3:0] c);
    int sel;
    sel = int'(c[2:0]);
    if (!c[3]) return 2 << sel;
    if (sel == 0) return 3;
    return 5 << (sel - 1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle model built from the requirements.
  logic       m_r1, m_r2, m_stb, m_sq;
  logic [3:0] m_pend, m_act;
  int         m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_r1 <= 1'b0; m_r2 <= 1'b0; m_stb <= 1'b0; m_sq <= 1'b0;
      m_pend <= 4'd0; m_act <= 4'd0; m_cnt <= 0;
    end else begin
      m_r1 <= 1'b1;
      m_r2 <= m_r1;
      if (m_r2) begin
        if (code_vld) m_pend <= ratio_code;
        if (m_cnt == 0) begin
          m_act <= m_pend;
          m_cnt <= ratio_ref(m_pend) - 1;
          m_stb <= 1'b1;
          m_sq  <= 1'b1;
        end else begin
          m_cnt <= m_cnt - 1;
          m_stb <= 1'b0;
          m_sq  <= ((m_cnt - 1) >= (ratio_ref(m_act) / 2));
        end
      end
    end
  end

  // Per-cycle comparison and period measurement.
  int  gap_cnt = 0;
  int  cur_exp = 0;
  bit  have_prev = 1'b0;
  logic [3:0] cur_code = 4'd0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cmp_strobe == m_stb, "R4 strobe", int'(cmp_strobe), int'(m_stb));
      check(div_sq == m_sq, "R7 square", int'(div_sq), int'(m_sq));
      if (cmp_strobe) begin
        if (have_prev) begin
          if (cur_code[3]) check(gap_cnt == cur_exp, "R3 period", gap_cnt, cur_exp);
          else             check(gap_cnt == cur_exp, "R2 period", gap_cnt, cur_exp);
        end
        have_prev = 1'b1;
        cur_code  = m_act;
        cur_exp   = ratio_ref(m_act);
        gap_cnt   = 1;
      end else begin
        gap_cnt++;
      end
    end
  end

  task automatic wait_strobe();
    do @(negedge clk); while (!cmp_strobe);
  endtask

  task automatic meas_gap(output int g);
    g = 0;
    do begin @(negedge clk); g++; end while (!cmp_strobe);
  endtask

  task automatic write_code(input logic [3:0] c);
    @(negedge clk);
    ratio_code = c;
    code_vld   = 1'b1;
    @(negedge clk);
    code_vld   = 1'b0;
  endtask

  initial begin
    int g;
    int first;
    void'($urandom(32'd24680));
    rst_n = 1'b0; ratio_code = 4'd0; code_vld = 1'b0;
    repeat (4) @(negedge clk);
    check(cmp_strobe == 1'b0, "R1 reset strobe", int'(cmp_strobe), 0);
    check(div_sq == 1'b0, "R1 reset square", int'(div_sq), 0);
    rst_n = 1'b1;
    first = 0;
    do begin @(negedge clk); first++; end while (!cmp_strobe && first < 10);
    check(first == 3, "R1 first strobe edge", first, 3);
    meas_gap(g);
    check(g == 2, "R1 default ratio", g, 2);

    // Sweep every code.
    for (int c = 0; c < 16; c++) begin
      write_code(4'(c));
      wait_strobe();
      wait_strobe();
      meas_gap(g);
      if (c >= 8) check(g == ratio_ref(4'(c)), "R3 sweep", g, ratio_ref(4'(c)));
      else        check(g == ratio_ref(4'(c)), "R2 sweep", g, ratio_ref(4'(c)));
    end

    // R6: new code mid-period must not shorten the running 256 period.
    write_code(4'h7);
    wait_strobe();
    wait_strobe();
    g = 0;
    do begin
      @(negedge clk);
      g++;
      if (g == 10) begin ratio_code = 4'h0; code_vld = 1'b1; end
      else code_vld = 1'b0;
    end while (!cmp_strobe);
    code_vld = 1'b0;
    check(g == 256, "R6 period kept", g, 256);
    meas_gap(g);
    check(g == 2, "R6 new ratio applied", g, 2);

    // R5: code without valid is ignored.
    ratio_code = 4'hF;
    repeat (40) @(negedge clk);
    meas_gap(g);
    check(g == 2, "R5 ignored code", g, 2);

    // R7 directed odd ratio: high 3, low 2 for ratio 5.
    write_code(4'h9);
    wait_strobe();
    wait_strobe();
    g = 0;
    while (div_sq) begin @(negedge clk); g++; end
    check(g == 3, "R7 odd high phase", g, 3);
    g = 0;
    while (!div_sq) begin @(negedge clk); g++; end
    check(g == 2, "R7 odd low phase", g, 2);

    // Random segment.
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      ratio_code = 4'($urandom_range(0, 15));
      code_vld   = ($urandom_range(0, 3) != 0);
      @(negedge clk);
      code_vld   = 1'b0;
      repeat ($urandom_range(1, 500)) @(negedge clk);
    end
    repeat (700) @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule